// File: doc/BRIEF.md
# Power Domain Gating Controller

This block decides the supply state of three gated logic domains, an always-switchable top domain and a backup domain. The decision is driven by a requested sleep mode and by activity from peripherals. A sleep code is captured only when a wait-for-interrupt strobe arrives while the CPU is running. The block then sets each gated domain to active, retention or off. In standby, each domain is kept in retention until a peripheral, event or DMA trigger needs it. The controller then raises that domain, and every domain below it, to active without waking the CPU.

Configuration inputs let software do three things: allow dynamic wake-up of the lower two domains, pin chosen domains active for all of standby, and link domains so that a request to one also raises another. A domain that comes up from retention or off reports ready only after a parameterised power-up count. Requests to that domain are not granted before then. A peripheral must keep its request asserted until it sees the grant; dropping it earlier withdraws the demand.

Top module: `pdg_ctrl`

## Requirements
- R1: After reset the CPU is running: every gated domain is active (state code 10), all ready flags are 1, `top_on` and `bkp_on` are 1, and `cpu_wake` is 0.
- R2: A sleep mode is entered only on a `wfi_strobe` cycle while running, with `sleep_code` equal to 2 (idle), 4 (standby), 5 (backup) or 6 (off). Any other code, a code presented without the strobe, and a strobe given while already asleep leave the state unchanged.
- R3: In idle, all gated domains stay active.
- R4: In standby, a gated domain with no demand is in retention (state code 01), and its ready flag is 0.
- R5: In standby, a request on `act_req[0]` or `act_req[1]` makes that domain active only when the matching `dyn_gate_en` bit is 1. A request to domain 2 is always honoured. Once the request is released, the domain returns to retention.
- R6: Whenever domain n is active, every domain with a lower index is also active.
- R7: A 1 in `force_active[n]` keeps domain n active throughout standby.
- R8: `link_sel` works as follows. 0 = no link. 1 = demand on domain 0 also raises domain 1. 2 = demand on domain 1 also raises domain 2. 3 = demand on domain 0 raises domains 1 and 2.
- R9: In backup, all gated domains are off (code 00), `top_on` is 0 and `bkp_on` is 1. In off mode, `bkp_on` is also 0, and only reset leaves that mode.
- R10: A domain entering active from retention or off raises its ready flag exactly PWRUP_CYC cycles after its state turns active. `act_grant[n]` equals `act_req[n]` gated by that ready flag.
- R11: `wake_irq` in idle, standby or backup returns the block to running. `cpu_wake` pulses for exactly one cycle, and the gated domains turn active on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wfi_strobe | input | 1 | One-cycle wait-for-interrupt strobe |
| sleep_code | input | 4 | Requested sleep mode code |
| wake_irq | input | 1 | Non-masked wake interrupt |
| act_req | input | NUM_GATED | Per-domain activity request |
| dyn_gate_en | input | NUM_DYN | Dynamic-wake enable for lower domains |
| force_active | input | NUM_GATED | Keep domain active in standby |
| link_sel | input | 2 | Domain link selection |
| pd_state | output | 2*NUM_GATED | Per-domain state code, domain n at bits [2n+1:2n] |
| pd_ready | output | NUM_GATED | Domain powered and usable |
| act_grant | output | NUM_GATED | Request accepted by a ready domain |
| top_on | output | 1 | Top domain powered |
| bkp_on | output | 1 | Backup domain powered |
| cpu_wake | output | 1 | One-cycle CPU wake pulse |

## Verification
The assertions take several things for granted about the inputs. All inputs are synchronous to `clk`. `wfi_strobe` and `wake_irq` are single-cycle pulses and are never raised together. `sleep_code` is stable while the strobe is high. The power-up count is at least one, so a freshly activated domain can never be ready on its first active cycle. The bench keeps to these assumptions: it changes every input on the falling edge, presents each strobe or interrupt for one cycle only, and leaves enough cycles between scenarios for any power-up count to finish.

// File: rtl/pdg_pkg.sv
package pdg_pkg;
  typedef enum logic [1:0] {
    PD_OFF = 2'b00,
    PD_RET = 2'b01,
    PD_ACT = 2'b10
  } pd_state_e;

  typedef enum logic [2:0] {
    M_RUN,
    M_IDLE,
    M_STBY,
    M_BKUP,
    M_OFF
  } mode_e;

  localparam logic [3:0] CODE_IDLE = 4'h2;
  localparam logic [3:0] CODE_STBY = 4'h4;
  localparam logic [3:0] CODE_BKUP = 4'h5;
  localparam logic [3:0] CODE_OFF  = 4'h6;
endpackage

// File: rtl/pdg_mode_fsm.sv
module pdg_mode_fsm
  import pdg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wfi_strobe,
  input  logic [3:0] sleep_code,
  input  logic       wake_irq,
  output mode_e      mode_q,
  output logic       cpu_wake
);
  mode_e mode_d;
  logic  wake_d;

  always_comb begin
    mode_d = mode_q;
    wake_d = 1'b0;
    unique case (mode_q)
      M_RUN: begin
        if (wfi_strobe) begin
          case (sleep_code)
            CODE_IDLE: mode_d = M_IDLE;
            CODE_STBY: mode_d = M_STBY;
            CODE_BKUP: mode_d = M_BKUP;
            CODE_OFF:  mode_d = M_OFF;
            default:   mode_d = M_RUN;
          endcase
        end
      end
      M_IDLE, M_STBY, M_BKUP: begin
        if (wake_irq) begin
          mode_d = M_RUN;
          wake_d = 1'b1;
        end
      end
      default: mode_d = M_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= M_RUN;
      cpu_wake <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      cpu_wake <= wake_d;
    end
  end

  a_r9_off_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_OFF) |=> (mode_q == M_OFF));
  a_r11_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wake |=> !cpu_wake);
  a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wfi_strobe && !wake_irq) |=> $stable(mode_q));
endmodule

// File: rtl/pdg_demand.sv
module pdg_demand
  import pdg_pkg::*;
#(
  parameter int NUM_GATED = 3,
  parameter int NUM_DYN   = 2
) (
  input  mode_e                      mode_q,
  input  logic [NUM_GATED-1:0]       act_req,
  input  logic [NUM_DYN-1:0]         dyn_gate_en,
  input  logic [NUM_GATED-1:0]       force_active,
  input  logic [1:0]                 link_sel,
  output logic [NUM_GATED-1:0][1:0]  target
);
  logic [NUM_GATED-1:0] en_full;
  logic [NUM_GATED-1:0] base;
  logic [NUM_GATED-1:0] linked;
  logic [NUM_GATED-1:0] want;

  for (genvar g = 0; g < NUM_GATED; g++) begin : g_en
    if (g < NUM_DYN) begin : g_dyn
      assign en_full[g] = dyn_gate_en[g];
    end else begin : g_always
      assign en_full[g] = 1'b1;
    end
  end

  always_comb begin
    base   = force_active | (act_req & en_full);
    linked = base;
    case (link_sel)
      2'd1: linked[1] = base[1] | base[0];
      2'd2: linked[2] = base[2] | base[1];
      2'd3: begin
        linked[1] = base[1] | base[0];
        linked[2] = base[2] | base[0];
      end
      default: linked = base;
    endcase
    want = linked;
    for (int i = NUM_GATED - 2; i >= 0; i--) begin
      want[i] = linked[i] | want[i+1];
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_GATED; i++) begin
      unique case (mode_q)
        M_RUN, M_IDLE: target[i] = PD_ACT;
        M_STBY:        target[i] = want[i] ? PD_ACT : PD_RET;
        default:       target[i] = PD_OFF;
      endcase
    end
  end
endmodule

// File: rtl/pdg_domain.sv
module pdg_domain
  import pdg_pkg::*;
#(
  parameter int PWRUP_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] target,
  input  logic       req,
  output logic [1:0] state,
  output logic       ready,
  output logic       grant
);
  localparam int CW = $clog2(PWRUP_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PD_ACT;
      cnt   <= '0;
    end else begin
      state <= target;
      if (target != PD_ACT) begin
        cnt <= '0;
      end else if (state != PD_ACT) begin
        cnt <= CW'(PWRUP_CYC);
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign ready = (state == PD_ACT) && (cnt == '0);
  assign grant = req & ready;

  a_r10_ready_after_active: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(state) == PD_ACT));
  a_r10_not_ready_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == PD_ACT) && ($past(state) != PD_ACT)) |-> !ready);
endmodule

// File: rtl/pdg_ctrl.sv
module pdg_ctrl
  import pdg_pkg::*;
#(
  parameter int NUM_GATED = 3,
  parameter int NUM_DYN   = 2,
  parameter int PWRUP_CYC = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wfi_strobe,
  input  logic [3:0]             sleep_code,
  input  logic                   wake_irq,
  input  logic [NUM_GATED-1:0]   act_req,
  input  logic [NUM_DYN-1:0]     dyn_gate_en,
  input  logic [NUM_GATED-1:0]   force_active,
  input  logic [1:0]             link_sel,
  output logic [2*NUM_GATED-1:0] pd_state,
  output logic [NUM_GATED-1:0]   pd_ready,
  output logic [NUM_GATED-1:0]   act_grant,
  output logic                   top_on,
  output logic                   bkp_on,
  output logic                   cpu_wake
);
  mode_e mode_q;
  logic [NUM_GATED-1:0][1:0] target;

  pdg_mode_fsm u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .wfi_strobe (wfi_strobe),
    .sleep_code (sleep_code),
    .wake_irq   (wake_irq),
    .mode_q     (mode_q),
    .cpu_wake   (cpu_wake)
  );

  pdg_demand #(.NUM_GATED(NUM_GATED), .NUM_DYN(NUM_DYN)) u_demand (
    .mode_q       (mode_q),
    .act_req      (act_req),
    .dyn_gate_en  (dyn_gate_en),
    .force_active (force_active),
    .link_sel     (link_sel),
    .target       (target)
  );

  for (genvar g = 0; g < NUM_GATED; g++) begin : g_dom
    logic [1:0] st;
    pdg_domain #(.PWRUP_CYC(PWRUP_CYC)) u_dom (
      .clk    (clk),
      .rst_n  (rst_n),
      .target (target[g]),
      .req    (act_req[g]),
      .state  (st),
      .ready  (pd_ready[g]),
      .grant  (act_grant[g])
    );
    assign pd_state[2*g +: 2] = st;
  end

  assign top_on = (mode_q != M_BKUP) && (mode_q != M_OFF);
  assign bkp_on = (mode_q != M_OFF);

  for (genvar h = 1; h < NUM_GATED; h++) begin : g_chk
    a_r6_lower_active: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_state[2*h +: 2] == PD_ACT) |-> (pd_state[2*(h-1) +: 2] == PD_ACT));
  end

  a_r9_backup_gated_off: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == M_BKUP) && ($past(mode_q) == M_BKUP)) |-> (pd_state == '0));
endmodule

// File: tb/pdg_ctrl_tb.sv
`timescale 1ns/1ps
module pdg_ctrl_tb_top;
  localparam int PU = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wfi_strobe = 1'b0;
  logic [3:0] sleep_code = 4'h0;
  logic       wake_irq = 1'b0;
  logic [2:0] act_req = '0;
  logic [1:0] dyn_gate_en = '0;
  logic [2:0] force_active = '0;
  logic [1:0] link_sel = '0;
  logic [5:0] pd_state;
  logic [2:0] pd_ready;
  logic [2:0] act_grant;
  logic       top_on, bkp_on, cpu_wake;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  pdg_ctrl #(.NUM_GATED(3), .NUM_DYN(2), .PWRUP_CYC(PU)) dut_i (
    .clk(clk), .rst_n(rst_n), .wfi_strobe(wfi_strobe), .sleep_code(sleep_code),
    .wake_irq(wake_irq), .act_req(act_req), .dyn_gate_en(dyn_gate_en),
    .force_active(force_active), .link_sel(link_sel), .pd_state(pd_state),
    .pd_ready(pd_ready), .act_grant(act_grant), .top_on(top_on),
    .bkp_on(bkp_on), .cpu_wake(cpu_wake)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic go_sleep(input logic [3:0] code);
    sleep_code = code; wfi_strobe = 1'b1;
    @(negedge clk); wfi_strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic wake_up();
    wake_irq = 1'b1;
    @(negedge clk); wake_irq = 1'b0;
    chk("R11 wake pulse", cpu_wake, 1);
    @(negedge clk);
    chk("R11 pulse ends", cpu_wake, 0);
    chk("R11 domains active", pd_state, 6'b101010);
    cyc(PU + 1);
  endtask

  task automatic t_reset();
    chk("R1 state", pd_state, 6'b101010);
    chk("R1 ready", pd_ready, 3'b111);
    chk("R1 top", top_on, 1);
    chk("R1 bkp", bkp_on, 1);
    chk("R1 wake", cpu_wake, 0);
  endtask

  task automatic t_ignore();
    sleep_code = 4'h4; cyc(3);
    chk("R2 no strobe", pd_state, 6'b101010);
    go_sleep(4'h3); cyc(1);
    chk("R2 bad code", pd_state, 6'b101010);
    chk("R2 bad code top", top_on, 1);
  endtask

  task automatic t_idle();
    go_sleep(4'h2);
    chk("R3 idle domains", pd_state, 6'b101010);
    chk("R3 idle ready", pd_ready, 3'b111);
    wake_up();
  endtask

  task automatic t_standby();
    go_sleep(4'h4);
    chk("R4 retention", pd_state, 6'b010101);
    chk("R4 not ready", pd_ready, 3'b000);
    go_sleep(4'h6);
    chk("R2 strobe asleep", pd_state, 6'b010101);
    chk("R2 strobe asleep bkp", bkp_on, 1);
  endtask

  task automatic t_dyn();
    dyn_gate_en = 2'b01; act_req = 3'b001;
    @(negedge clk);
    chk("R5 pd0 active", pd_state, 6'b010110);
    chk("R10 not ready at entry", pd_ready[0], 0);
    cyc(PU - 1);
    chk("R10 not ready early", pd_ready[0], 0);
    chk("R10 no grant early", act_grant[0], 0);
    cyc(1);
    chk("R10 ready on time", pd_ready[0], 1);
    chk("R10 grant", act_grant[0], 1);
    act_req = 3'b000; @(negedge clk);
    chk("R5 back to retention", pd_state, 6'b010101);
    dyn_gate_en = 2'b00; act_req = 3'b001; cyc(2);
    chk("R5 disabled ignored", pd_state, 6'b010101);
    chk("R5 disabled no grant", act_grant, 3'b000);
    dyn_gate_en = 2'b10; act_req = 3'b010; @(negedge clk);
    chk("R6 pd1 pulls pd0", pd_state, 6'b011010);
    dyn_gate_en = 2'b00; act_req = 3'b100; @(negedge clk);
    chk("R5 R6 pd2 honoured", pd_state, 6'b101010);
    act_req = 3'b000; @(negedge clk);
    chk("R5 pd2 release", pd_state, 6'b010101);
  endtask

  task automatic t_force();
    force_active = 3'b010; cyc(3);
    chk("R7 forced pd1", pd_state, 6'b011010);
    force_active = 3'b000; @(negedge clk);
  endtask

  task automatic t_link();
    dyn_gate_en = 2'b11;
    link_sel = 2'd1; act_req = 3'b001; @(negedge clk);
    chk("R8 link1", pd_state, 6'b011010);
    link_sel = 2'd2; act_req = 3'b010; @(negedge clk);
    chk("R8 link2", pd_state, 6'b101010);
    act_req = 3'b001; @(negedge clk);
    chk("R8 link2 pd0 alone", pd_state, 6'b010110);
    link_sel = 2'd3; @(negedge clk);
    chk("R8 link3", pd_state, 6'b101010);
    link_sel = 2'd0; @(negedge clk);
    chk("R8 no link", pd_state, 6'b010110);
    act_req = 3'b000; dyn_gate_en = 2'b00; @(negedge clk);
    wake_up();
    chk("R10 ready after wake", pd_ready, 3'b111);
  endtask

  task automatic t_backup();
    go_sleep(4'h5);
    chk("R9 backup off", pd_state, 6'b000000);
    chk("R9 backup top", top_on, 0);
    chk("R9 backup bkp", bkp_on, 1);
    act_req = 3'b111; cyc(2);
    chk("R9 backup req ignored", pd_state, 6'b000000);
    act_req = 3'b000;
    wake_up();
  endtask

  task automatic t_off();
    go_sleep(4'h6);
    chk("R9 off domains", pd_state, 6'b000000);
    chk("R9 off bkp", bkp_on, 0);
    wake_irq = 1'b1; @(negedge clk); wake_irq = 1'b0; @(negedge clk);
    chk("R9 off no wake", cpu_wake, 0);
    chk("R9 off stays", {top_on, bkp_on}, 2'b00);
    rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(1);
    t_reset();
  endtask

  initial begin
    #(20 * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1'b1; cyc(1);
    t_reset();
    t_ignore();
    t_idle();
    t_standby();
    t_dyn();
    t_force();
    t_link();
    t_backup();
    t_off();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule